// File: doc/BRIEF.md
# Banked register RAM selector

This block is the data-memory side of a small processor, built from RAM chips that each hold sixteen 56-bit registers. The processor first latches a register address with a select operation. It then reads or writes through that selection. A plain access always goes to the exact latched register. An indexed access keeps the chip part of the latched address and puts a 4-bit index in place of the low hex digit. This reaches any register of the current chip without a new select.

The populated chips are a contiguous run of chip numbers, set by a base parameter and a count parameter. The chip number is latched address bits [9:4]. A select that names an address outside that run, or with bits [11:10] nonzero, leaves the memory deselected. While deselected, reads give zero, writes have no effect and a flag output is high. Select and write act on the rising clock edge. Read data is combinational, so it is valid in the same cycle as the request.

Top module: `regbank_sel`

## Requirements
- R1: When `sel_en` is high at a rising edge, bits [11:0] of `sel_data` become the latched address. All higher bits of `sel_data` are ignored. When `sel_en` is low, the latched selection holds.
- R2: A latched address is populated when bits [11:10] are zero and its chip number, bits [9:4], lies in BASE_CHIP to BASE_CHIP+NUM_CHIPS-1. `none_sel` is 0 after a populated select and 1 after any other select (for example 010 with the default base 0x1C).
- R3: With `rd_idx_en` = 0, `rd_data` is the register at the exact latched address, in the same cycle.
- R4: With `rd_idx_en` = 1, `rd_data` is the register whose bits [9:4] come from the latched address and whose bits [3:0] are `rd_idx`. With 1FF latched, index 14 reads 1FE. With 1F0 latched, index 15 reads 1FF. Index 0 reads offset 0, the same register a plain read gives while offset 0 is latched.
- R5: With `wr_en` = 1 and `wr_idx_en` = 0, `wr_data` is stored at the exact latched address on the rising edge.
- R6: With `wr_en` = 1 and `wr_idx_en` = 1, `wr_data` is stored at offset `wr_idx` (any of 0 to 15) of the latched chip.
- R7: While `none_sel` is 1, `rd_data` is all zeros and writes change no register.
- R8: A low `rst_n` at a rising edge deselects the memory (`none_sel` = 1). Register contents are kept across reset.
- R9: A write and a select in the same cycle: the write uses the selection that was latched before that edge.
- R10: Every register keeps all 56 bits of the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the selection |
| sel_en | input | 1 | Latch a new register address |
| sel_data | input | 56 | Data word; bits [11:0] carry the address to latch |
| rd_idx_en | input | 1 | 1: indexed read, 0: plain read |
| rd_idx | input | 4 | Register index within the chip for indexed reads |
| rd_data | output | 56 | Read word, combinational |
| wr_en | input | 1 | Write request |
| wr_idx_en | input | 1 | 1: indexed write, 0: plain write |
| wr_idx | input | 4 | Register index within the chip for indexed writes |
| wr_data | input | 56 | Word to write |
| none_sel | output | 1 | High while no chip is selected |

## Verification
The directed cases use chip 1F. One selects offset 0 and reads index 15. One selects offset F and reads index 14. One selects the unpopulated address 010. Together they separate a decoder that substitutes the index from one that adds it to the latched offset, and a correct deselect from one that leaves the last chip active. A select and a write in the same cycle show whether the write takes the old or the new address. A reset in the middle of the run shows that the selection clears while the contents stay. The constrained-random phase mixes populated and unpopulated addresses, plain and indexed accesses and full-width random words. Every read is compared with a model kept in the bench, so a wrong chip slot, a swapped offset or a dropped data bit shows up as a word mismatch.

// File: rtl/regbank_pkg.sv
// Package: shared constants and the latched-address layout for the banked
// register RAM. Assumes 16 registers per chip and a 12-bit select field.
package regbank_pkg;
    localparam int WORD_W      = 56;   // register width in bits
    localparam int OFF_W       = 4;    // offset bits within one chip
    localparam int REGS_PER    = 1 << OFF_W;
    localparam int CHIP_W      = 6;    // chip-number field width
    localparam int TOP_W       = 2;    // unused upper address bits
    localparam int SEL_W       = TOP_W + CHIP_W + OFF_W;

    // Latched address: the chip number sits at bits [9:4], the offset at [3:0]
    typedef struct packed {
        logic [TOP_W-1:0]  top;
        logic [CHIP_W-1:0] chip;
        logic [OFF_W-1:0]  off;
    } sel_addr_t;
endpackage

// File: rtl/regbank_sel_latch.sv
// Module: address latch and chip decoder. It latches the select field and
// decides once, at select time, whether the address names a populated chip.
// It also stores the slot number of that chip. Assumes BASE_CHIP+NUM_CHIPS
// fits in the chip field.
module regbank_sel_latch
    import regbank_pkg::*;
#(
    parameter int BASE_CHIP = 28,
    parameter int NUM_CHIPS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  sel_addr_t         sel_in,
    output sel_addr_t         cur_addr,
    output logic              cur_hit,
    output logic [SLOT_W-1:0] cur_slot
);
    logic              in_hit;
    logic [SLOT_W-1:0] in_slot;
    sel_addr_t         addr_q;
    logic              hit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              rst_seen_q;

    // Decode the incoming address against the populated chip range
    always_comb begin
        in_hit  = (sel_in.top == '0) &&
                  (int'(sel_in.chip) >= BASE_CHIP) &&
                  (int'(sel_in.chip) <  BASE_CHIP + NUM_CHIPS);
        in_slot = in_hit ? SLOT_W'(int'(sel_in.chip) - BASE_CHIP) : '0;
    end

    // Hold the current selection; reset deselects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            hit_q  <= 1'b0;
            slot_q <= '0;
        end else if (sel_en) begin
            addr_q <= sel_in;
            hit_q  <= in_hit;
            slot_q <= in_slot;
        end
    end

    assign cur_addr = addr_q;
    assign cur_hit  = hit_q;
    assign cur_slot = slot_q;

    // Remember that the last edge saw reset, for the reset check below
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1
    sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> (addr_q == $past(sel_in)));

    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> ($stable(addr_q) && $stable(hit_q)));

    // R2
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_en && ((sel_in.top != '0) || (int'(sel_in.chip) < BASE_CHIP)))
        |=> !hit_q);

    // R8
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            rst_clear_chk: assert (!hit_q);
        end
    end
endmodule

// File: rtl/regbank_offset.sv
// Module: offset substitution. An indexed access replaces the latched low
// digit with the index. A plain access keeps the latched digit. Purely
// combinational.
module regbank_offset
    import regbank_pkg::*;
(
    input  logic [OFF_W-1:0] cur_off,
    input  logic             rd_idx_en,
    input  logic [OFF_W-1:0] rd_idx,
    input  logic             wr_idx_en,
    input  logic [OFF_W-1:0] wr_idx,
    output logic [OFF_W-1:0] rd_off,
    output logic [OFF_W-1:0] wr_off
);
    // Pick the effective offsets for the read and write paths
    always_comb begin
        rd_off = rd_idx_en ? rd_idx : cur_off;
        wr_off = wr_idx_en ? wr_idx : cur_off;
    end
endmodule

// File: rtl/regbank_store.sv
// Module: storage for NUM_CHIPS chips of REGS_PER registers each, one
// generate instance per chip. There is one write port and one combinational
// read port. The read is forced to zero when no chip is hit. Contents have no
// reset.
module regbank_store
    import regbank_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int SLOT_W    = 2,
    parameter int DATA_W    = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rd_hit,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_word
);
    logic [NUM_CHIPS-1:0] chip_we;
    logic [DATA_W-1:0]    chip_rd [NUM_CHIPS];

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
        logic [DATA_W-1:0] bank [REGS_PER];

        // Write enable for this chip only
        assign chip_we[g] = wr_fire && (int'(wr_slot) == g);

        // Store the word at the effective offset
        always_ff @(posedge clk) begin
            if (chip_we[g]) begin
                bank[wr_off] <= wr_word;
            end
        end

        // Read this chip at the effective offset
        assign chip_rd[g] = bank[rd_off];

        // R5 R6 R10
        write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chip_we[g] |=> (bank[$past(wr_off)] == $past(wr_word)));
    end

    // Route the selected chip to the output, or zero when deselected
    always_comb begin
        rd_word = '0;
        if (rd_hit && (int'(rd_slot) < NUM_CHIPS)) begin
            rd_word = chip_rd[rd_slot];
        end
    end

    // R6
    one_chip_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_we));
endmodule

// File: rtl/regbank_sel.sv
// Module: top of the banked register RAM selector. It ties together the
// address latch, offset substitution and storage. Writes use the selection
// held before the edge. Reads are combinational from that selection.
module regbank_sel
    import regbank_pkg::*;
#(
    parameter int BASE_CHIP = 28,
    parameter int NUM_CHIPS = 4,
    parameter int DATA_W    = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  logic [DATA_W-1:0] sel_data,
    input  logic              rd_idx_en,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_idx_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              none_sel
);
    localparam int SLOT_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;

    sel_addr_t         cur_addr;
    logic              cur_hit;
    logic [SLOT_W-1:0] cur_slot;
    logic [OFF_W-1:0]  rd_off;
    logic [OFF_W-1:0]  wr_off;
    logic              wr_fire;

    regbank_sel_latch #(
        .BASE_CHIP(BASE_CHIP),
        .NUM_CHIPS(NUM_CHIPS),
        .SLOT_W   (SLOT_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_en  (sel_en),
        .sel_in  (sel_addr_t'(sel_data[SEL_W-1:0])),
        .cur_addr(cur_addr),
        .cur_hit (cur_hit),
        .cur_slot(cur_slot)
    );

    regbank_offset u_offset (
        .cur_off  (cur_addr.off),
        .rd_idx_en(rd_idx_en),
        .rd_idx   (rd_idx),
        .wr_idx_en(wr_idx_en),
        .wr_idx   (wr_idx),
        .rd_off   (rd_off),
        .wr_off   (wr_off)
    );

    // A write only lands when a chip is selected
    assign wr_fire  = wr_en && cur_hit;
    assign none_sel = !cur_hit;

    regbank_store #(
        .NUM_CHIPS(NUM_CHIPS),
        .SLOT_W   (SLOT_W),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_fire(wr_fire),
        .wr_slot(cur_slot),
        .wr_off (wr_off),
        .wr_word(wr_data),
        .rd_hit (cur_hit),
        .rd_slot(cur_slot),
        .rd_off (rd_off),
        .rd_word(rd_data)
    );

    // R7
    dead_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        none_sel |-> (rd_data == '0));
endmodule

// File: tb/test_regbank_sel.sv
`timescale 1ns/1ps
module test_regbank_sel;
    localparam int BASE = 28;
    localparam int NCH  = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_en, rd_idx_en, wr_en, wr_idx_en;
    logic [55:0] sel_data, wr_data, rd_data;
    logic [3:0]  rd_idx, wr_idx;
    logic        none_sel;

    int n_chk  = 0;
    int n_fail = 0;

    logic [55:0] m_mem [NCH*16];
    logic [11:0] m_addr;
    bit          m_hit;

    always #2 clk = ~clk;

    regbank_sel #(.BASE_CHIP(BASE), .NUM_CHIPS(NCH)) i_regbank_sel (
        .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .sel_data(sel_data),
        .rd_idx_en(rd_idx_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx_en(wr_idx_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .none_sel(none_sel)
    );

    function automatic bit populated(input logic [11:0] a);
        return (a[11:10] == 2'b00) && (int'(a[9:4]) >= BASE) &&
               (int'(a[9:4]) < BASE + NCH);
    endfunction

    function automatic int mem_index(input logic [11:0] a, input logic [3:0] off);
        return (int'(a[9:4]) - BASE) * 16 + int'(off);
    endfunction

    function automatic logic [55:0] exp_read(input bit ie, input logic [3:0] ix);
        if (!m_hit) return '0;
        return m_mem[mem_index(m_addr, ie ? ix : m_addr[3:0])];
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [55:0] act, input logic [55:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, clock, update model
    task automatic step(input bit s, input logic [55:0] sd, input bit rie,
                        input logic [3:0] ri, input bit we, input bit wie,
                        input logic [3:0] wi, input logic [55:0] wd, input bit chk);
        logic [55:0] e;
        sel_en = s; sel_data = sd; rd_idx_en = rie; rd_idx = ri;
        wr_en = we; wr_idx_en = wie; wr_idx = wi; wr_data = wd;
        #1;
        if (chk) begin
            e = exp_read(rie, ri);
            check(rd_data === e, !m_hit ? "R7 read while deselected" :
                  (rie ? "R4 indexed read" : "R3 plain read"), rd_data, e);
            check(none_sel === !m_hit, "R2 none_sel", 56'(none_sel), 56'(!m_hit));
        end
        @(posedge clk);
        if (we && m_hit) m_mem[mem_index(m_addr, wie ? wi : m_addr[3:0])] = wd;
        if (s) begin
            m_addr = sd[11:0];
            m_hit  = populated(sd[11:0]);
        end
        @(negedge clk);
    endtask

    task automatic sel(input logic [11:0] a);
        step(1, {44'h0, a}, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic rd(input bit ie, input logic [3:0] ix);
        step(0, 0, ie, ix, 0, 0, 0, 0, 1);
    endtask

    function automatic logic [55:0] rnd56();
        return {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
    endfunction

    initial begin
        void'($urandom(32'd4093));
        rst_n = 1'b0; sel_en = 0; sel_data = 0; rd_idx_en = 0; rd_idx = 0;
        wr_en = 0; wr_idx_en = 0; wr_idx = 0; wr_data = 0;
        m_addr = 0; m_hit = 0;
        @(negedge clk); @(negedge clk);
        // R8: reset state
        check(none_sel === 1'b1, "R8 reset deselects", 56'(none_sel), 56'd1);
        check(rd_data === '0, "R8/R7 reset read zero", rd_data, '0);
        rst_n = 1'b1;

        // Fill every chip through indexed writes (R6)
        for (int c = 0; c < NCH; c++) begin
            step(1, {44'h0, 2'b00, 6'(BASE + c), 4'h7}, 0, 0, 0, 0, 0, 0, 0);
            for (int k = 0; k < 16; k++)
                step(0, 0, 0, 0, 1, 1, 4'(k), rnd56(), 0);
        end

        // Directed: chip 1F offset 0 and offset F
        sel(12'h1F0);
        rd(0, 0);                        // R3 plain at offset 0
        rd(1, 4'hF);                     // R4 index 15 -> 1FF
        rd(1, 4'h0);                     // R4 index 0 equals plain at offset 0
        sel(12'h1FF);
        rd(0, 0);                        // R3 plain at 1FF
        rd(1, 4'hE);                     // R4 index 14 -> 1FE
        // R5 plain write, R10 full width
        step(0, 0, 0, 0, 1, 0, 0, 56'hFF_FFFF_FFFF_FFFF, 1);
        rd(0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 56'h80_0000_0000_0001, 1);
        rd(0, 0);
        // R2/R7: unpopulated select, write ignored
        sel(12'h010);
        rd(0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 56'h12_3456_789A_BCDE, 1);
        step(0, 0, 0, 0, 1, 1, 4'h0, 56'h12_3456_789A_BCDE, 1);
        sel(12'h1F0);
        rd(1, 4'hF);                     // R7 1FF unchanged
        rd(0, 0);                        // R7 1F0 unchanged
        // R2: upper address bits nonzero
        sel(12'h5F0);
        rd(1, 4'h3);
        // R9: select and write in the same cycle
        sel(12'h1F3);
        step(1, {44'h0, 12'h1E5}, 0, 0, 1, 0, 0, 56'hA5_A5A5_5A5A_C3C3, 1);
        rd(0, 0);                        // R9 1E5 untouched
        sel(12'h1F3);
        rd(0, 0);                        // R9 write landed on 1F3
        // R1: upper sel_data bits ignored
        step(1, {44'hFFF_FFFF_FFFF, 12'h1C9}, 0, 0, 0, 0, 0, 0, 1);
        rd(0, 0);
        // R8: reset mid-run keeps contents
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        m_hit = 0; m_addr = 0;
        check(none_sel === 1'b1, "R8 mid-run reset", 56'(none_sel), 56'd1);
        rst_n = 1'b1;
        sel(12'h1C9);
        rd(0, 0);                        // R8 contents kept

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            int r = int'($urandom % 100);
            if ($urandom % 5 != 0)
                a = {2'b00, 6'(BASE + int'($urandom % NCH)), 4'($urandom)};
            else
                a = 12'($urandom);
            step(r < 25, {rnd56()} & ~56'hFFF | 56'(a), $urandom % 2 == 1,
                 4'($urandom), r >= 60, $urandom % 2 == 1, 4'($urandom), rnd56(), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule